// File: doc/BRIEF.md
# Dual I/O Serial Flash Read Controller

This block sits on the host side of a serial NOR flash. It runs one fast read per request, using two bidirectional data lines. A request gives a 24-bit start address and a byte count. The controller then lowers chip select and clocks out the read opcode on line io0 alone, one bit per serial clock. Next it sends the address two bits per clock on io0 and io1, and runs four dummy clocks. During the dummy clocks it releases both lines so that the flash can drive them. It then collects two bits per clock until the requested number of bytes has arrived. Each byte leaves on a valid/ready stream. If the consumer stalls, the serial clock is held low between bytes and chip select stays asserted, so no data is lost.

The serial clock is the system clock divided by an even factor. It runs in mode 0: it idles low, the controller changes its outputs only when the serial clock falls, and it samples on the rising edge. A parameter selects the device size (0: 2 Mbit, 1: 1 Mbit, 2: 512 Kbit), and the address bits above that size are sent as zero. After chip select rises, a programmable deselect time must pass before the next command can start.

The state machine has these states:
- IDLE waits for a request.
- SETUP lowers chip select and presents the first opcode bit for half a serial period.
- CMD covers 8 clocks.
- ADDR covers 12 clocks.
- DUMMY covers 4 clocks, with the lines released.
- DATA receives bytes.
- STALL holds the serial clock low while a received byte waits at the stream.
- FINISH returns the serial clock low after the last byte.
- GAP keeps chip select high for the deselect time.

The transitions are:
- IDLE→SETUP on an accepted request.
- SETUP→CMD after half a period.
- CMD→ADDR on the falling edge after clock 7.
- ADDR→DUMMY on the falling edge after clock 19.
- DUMMY→DATA on the falling edge after clock 23.
- DATA→STALL when the next byte would start while the held byte is still unaccepted.
- STALL→DATA once the held byte is taken.
- DATA→FINISH on the last bit pair of the last byte.
- FINISH→GAP on the closing fall, which raises chip select.
- GAP→IDLE after the deselect count.

Top module: `dual_io_flash_reader`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, busy is 0, out_valid is 0, and io0_en and io1_en are both 0.
- R2: Over the first 8 rising sclk edges after cs_n falls, io0 carries the opcode 0xBB, MSB first, and io1_en stays 0.
- R3: On rising edges 8 to 19, the address goes out two bits per clock. io1 carries the odd bit and io0 the even bit, starting with bits 23 and 22.
- R4: Address bits at and above bit 18 (DEV_SIZE 0), bit 17 (DEV_SIZE 1) or bit 16 (DEV_SIZE 2) are sent as zero, whatever the request holds.
- R5: io0_en and io1_en are 0 from the falling edge that ends clock 19 until cs_n rises, and so are 0 when the flash starts to drive after clock 23.
- R6: Each byte is taken over 4 rising edges, MSB first. io1 carries bits 7,5,3,1 and io0 carries bits 6,4,2,0. Bytes leave in address order, exactly req_len of them per request, and each is held with out_data stable while out_valid=1 and out_ready=0.
- R7: While the serial clock runs, each high phase of sclk lasts exactly CLK_DIV/2 system clocks.
- R8: The first rising edge of a byte never occurs while out_valid is 1. Under back-pressure sclk waits low and cs_n stays 0, so each request uses one chip-select low period.
- R9: After the last byte, sclk is low when cs_n rises. done pulses for one cycle exactly when cs_n rises. cs_n then stays 1 for at least DESEL_CYCLES system clocks before it falls again.
- R10: busy is 1 from the cycle after a request is accepted until the deselect time ends. A req_valid seen while busy is 1 starts no transfer.
- R11: A request with req_len = 0 is ignored: busy stays 0 and cs_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Transfer or deselect time in progress |
| done | output | 1 | One-cycle pulse when chip select rises |
| out_valid | output | 1 | Received byte available |
| out_data | output | 8 | Received byte |
| out_ready | input | 1 | Consumer accepts the byte |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock |
| io0_out | output | 1 | Drive value for line io0 |
| io0_en | output | 1 | Output enable for line io0 |
| io0_in | input | 1 | Sampled value of line io0 |
| io1_out | output | 1 | Drive value for line io1 |
| io1_en | output | 1 | Output enable for line io1 |
| io1_in | input | 1 | Sampled value of line io1 |

## Verification
Two things can fall in the same cycle: the consumer draining the held byte, and the half-period tick that would raise sclk for the next byte's first bit. The bench provokes this with out_ready patterns of different duty and period, so that releases land on every phase of the divider. A scoreboard judges the result: every expected byte must arrive exactly once and in order. A flash model checks that out_valid is 0 at each first-bit rising edge and that the total clock count per chip-select period matches the byte count.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    localparam int ADDR_W = 24;
    localparam logic [7:0] RD_DUAL_OP = 8'hBB;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_CMD,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_STALL,
        ST_FINISH,
        ST_GAP
    } fdr_state_t;

    // number of meaningful address bits for each device-size code
    function automatic int kept_addr_bits(input int dev_size);
        case (dev_size)
            0:       return 18;
            1:       return 17;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/fdr_half_tick.sv
module fdr_half_tick #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clr,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || tick) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fdr_rx_pack.sv
module fdr_rx_pack (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic       line_hi,
    input  logic       line_lo,
    output logic       at_first,
    output logic       at_last,
    output logic       out_valid,
    output logic [7:0] out_data,
    input  logic       out_ready
);
    logic [1:0] pair_cnt;
    logic [5:0] part_sr;
    logic       capture;

    assign at_first = (pair_cnt == 2'd0);
    assign at_last  = (pair_cnt == 2'd3);
    assign capture  = sample && at_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pair_cnt  <= '0;
            part_sr   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            if (sample) begin
                pair_cnt <= pair_cnt + 1'b1;
                part_sr  <= {part_sr[3:0], line_hi, line_lo};
            end
            if (out_valid && out_ready) begin
                out_valid <= 1'b0;
            end
            if (capture) begin
                out_data  <= {part_sr, line_hi, line_lo};
                out_valid <= 1'b1;
            end
        end
    end

    // a finished byte never lands on an unaccepted one
    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        capture |-> !out_valid);

    // a waiting byte is held unchanged
    assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/dual_io_flash_reader.sv
module dual_io_flash_reader
    import fdr_pkg::*;
#(
    parameter int DEV_SIZE     = 0,
    parameter int CLK_DIV      = 4,
    parameter int DESEL_CYCLES = 4,
    parameter int LEN_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [23:0]       req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              cs_n,
    output logic              sclk,
    output logic              io0_out,
    output logic              io0_en,
    input  logic              io0_in,
    output logic              io1_out,
    output logic              io1_en,
    input  logic              io1_in
);
    localparam int HALF      = CLK_DIV / 2;
    localparam int KEEP      = kept_addr_bits(DEV_SIZE);
    localparam logic [ADDR_W-1:0] ADDR_MASK = {ADDR_W{1'b1}} >> (ADDR_W - KEEP);
    localparam int GAP_W     = $clog2(DESEL_CYCLES + 1);
    localparam int HL_W      = $clog2(HALF + 2);
    localparam logic [3:0] CMD_LAST   = 4'd7;
    localparam logic [3:0] ADDR_LAST  = 4'd11;
    localparam logic [3:0] DUMMY_LAST = 4'd3;

    fdr_state_t state_q, state_d;

    logic              sclk_q;
    logic [3:0]        ph_cnt;
    logic [LEN_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic [GAP_W-1:0]  gap_cnt;

    logic tick, run, rise, fall, stall_now, sample, accept;
    logic rx_first, rx_last;
    logic [4:0] hi_idx, lo_idx;

    assign run = (state_q == ST_SETUP) || (state_q == ST_CMD) || (state_q == ST_ADDR) ||
                 (state_q == ST_DUMMY) || (state_q == ST_DATA) || (state_q == ST_FINISH);

    fdr_half_tick #(.HALF(HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .clr   (!run),
        .tick  (tick)
    );

    assign rise      = tick && !sclk_q && (state_q != ST_SETUP);
    assign fall      = tick && sclk_q;
    assign stall_now = (state_q == ST_DATA) && rise && rx_first && out_valid;
    assign sample    = (state_q == ST_DATA) && rise && !stall_now;
    assign accept    = (state_q == ST_IDLE) && req_valid && (req_len != '0);

    fdr_rx_pack u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample),
        .line_hi   (io1_in),
        .line_lo   (io0_in),
        .at_first  (rx_first),
        .at_last   (rx_last),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SETUP;
            ST_SETUP:  if (tick) state_d = ST_CMD;
            ST_CMD:    if (fall && ph_cnt == CMD_LAST) state_d = ST_ADDR;
            ST_ADDR:   if (fall && ph_cnt == ADDR_LAST) state_d = ST_DUMMY;
            ST_DUMMY:  if (fall && ph_cnt == DUMMY_LAST) state_d = ST_DATA;
            ST_DATA: begin
                if (stall_now)
                    state_d = ST_STALL;
                else if (sample && rx_last && left_q == LEN_W'(1))
                    state_d = ST_FINISH;
            end
            ST_STALL:  if (!out_valid) state_d = ST_DATA;
            ST_FINISH: if (tick) state_d = ST_GAP;
            ST_GAP:    if (gap_cnt == GAP_W'(DESEL_CYCLES - 1)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sclk_q  <= 1'b0;
            ph_cnt  <= '0;
            left_q  <= '0;
            addr_q  <= '0;
            gap_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q <= req_addr & ADDR_MASK;
                left_q <= req_len;
            end
            if (state_q == ST_FINISH) begin
                if (tick) sclk_q <= 1'b0;
            end else if (state_q == ST_CMD || state_q == ST_ADDR ||
                         state_q == ST_DUMMY) begin
                if (tick) sclk_q <= !sclk_q;
            end else if (state_q == ST_DATA) begin
                if (tick && !stall_now) sclk_q <= !sclk_q;
            end
            if (state_q != state_d)
                ph_cnt <= '0;
            else if (fall)
                ph_cnt <= ph_cnt + 1'b1;
            if (sample && rx_last)
                left_q <= left_q - 1'b1;
            if (state_q == ST_GAP)
                gap_cnt <= gap_cnt + 1'b1;
            else
                gap_cnt <= '0;
        end
    end

    assign hi_idx = 5'd23 - {ph_cnt, 1'b0};
    assign lo_idx = hi_idx - 5'd1;

    // outputs
    always_comb begin
        cs_n    = (state_q == ST_IDLE) || (state_q == ST_GAP);
        sclk    = sclk_q;
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_GAP) && (gap_cnt == '0);
        io0_out = 1'b0;
        io0_en  = 1'b0;
        io1_out = 1'b0;
        io1_en  = 1'b0;
        unique case (state_q)
            ST_SETUP, ST_CMD: begin
                io0_out = RD_DUAL_OP[3'd7 - ph_cnt[2:0]];
                io0_en  = 1'b1;
            end
            ST_ADDR: begin
                io1_out = addr_q[hi_idx];
                io0_out = addr_q[lo_idx];
                io0_en  = 1'b1;
                io1_en  = 1'b1;
            end
            default: ;
        endcase
    end

    // high phase length tracker for the clock-shape assertion
    logic [HL_W-1:0] hi_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hi_len <= '0;
        else if (sclk_q) hi_len <= hi_len + 1'b1;
        else             hi_len <= '0;
    end

    assert_high_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_q) |-> (hi_len == HL_W'(HALF)));

    assert_clock_low_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk_q);

    assert_done_on_cs_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $rose(cs_n));

    assert_lines_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n) && $past(!io0_en) && $past(!io1_en)) |-> (!io0_en && !io1_en));

    assert_start_needs_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_len != '0));

endmodule

// File: tb/sim_dual_io_flash_reader.sv
module sim_dual_io_flash_reader;
    localparam int CLK_DIV = 4;
    localparam int HALF    = CLK_DIV / 2;
    localparam int DESEL   = 5;
    localparam int DEV     = 2;
    localparam int LEN_W   = 16;
    localparam logic [23:0] MASK = 24'h00FFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic             req_valid = 1'b0;
    logic [23:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             busy, done, out_valid, out_ready;
    logic [7:0]       out_data;
    logic             cs_n, sclk, io0_out, io0_en, io1_out, io1_en;
    logic             io0_ln, io1_ln;

    logic fdrv = 1'b0, f0 = 1'b0, f1 = 1'b0;
    assign io0_ln = io0_en ? io0_out : (fdrv ? f0 : 1'b0);
    assign io1_ln = io1_en ? io1_out : (fdrv ? f1 : 1'b0);

    dual_io_flash_reader #(
        .DEV_SIZE(DEV), .CLK_DIV(CLK_DIV), .DESEL_CYCLES(DESEL), .LEN_W(LEN_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .done(done), .out_valid(out_valid),
        .out_data(out_data), .out_ready(out_ready), .cs_n(cs_n), .sclk(sclk),
        .io0_out(io0_out), .io0_en(io0_en), .io0_in(io0_ln),
        .io1_out(io1_out), .io1_en(io1_en), .io1_in(io1_ln)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] byte_at(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    logic [7:0]  sb_q[$];
    logic [7:0]  exp_b;
    logic [23:0] exp_addr = '0;
    int          exp_len = 0;
    int          rdy_mode = 0;
    int          cyc = 0;
    int          done_cnt = 0;
    int          cs_fall_cnt = 0;

    // consumer ready pattern
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            cyc++;
            case (rdy_mode)
                0:       out_ready <= 1'b1;
                1:       out_ready <= (cyc % 7) < 3;
                default: out_ready <= (cyc % 45) == 0;
            endcase
        end
    end

    // flash model
    int          fc = 0;
    logic [7:0]  f_cmd = '0;
    logic [23:0] f_addr = '0;
    bit          in_xfer = 1'b0;

    always @(negedge cs_n) if (rst_n) begin
        in_xfer = 1'b1; fc = 0; f_cmd = '0; f_addr = '0; fdrv = 1'b0;
        cs_fall_cnt++;
    end

    always @(posedge cs_n) if (in_xfer) begin
        in_xfer = 1'b0;
        fdrv = 1'b0;
        chk(fc == 24 + 4 * exp_len, "R6", "clocks per select", fc, 24 + 4 * exp_len);
    end

    always @(posedge sclk) if (in_xfer) begin
        if (fc < 8) begin
            f_cmd = {f_cmd[6:0], io0_ln};
            chk(!io1_en, "R2", "io1 driven in command", io1_en, 0);
        end else if (fc < 20) begin
            f_addr = {f_addr[21:0], io1_ln, io0_ln};
        end else if (fc >= 24 && ((fc - 24) % 4) == 0) begin
            chk(!out_valid, "R8", "byte started while byte held", out_valid, 0);
        end
        fc++;
        if (fc == 8)
            chk(f_cmd == 8'hBB, "R2", "opcode", f_cmd, 8'hBB);
        if (fc == 20) begin
            chk(f_addr[15:0] == exp_addr[15:0], "R3", "address low", f_addr[15:0], exp_addr[15:0]);
            chk(f_addr[23:16] == 8'h00, "R4", "masked upper bits", f_addr[23:16], 0);
        end
    end

    always @(negedge sclk) if (in_xfer && fc >= 24) begin
        automatic int j = (fc - 24) / 4;
        automatic int p = (fc - 24) % 4;
        automatic logic [7:0] b = byte_at(f_addr + 24'(j));
        chk(!io0_en && !io1_en, "R5", "host drives during data", {io1_en, io0_en}, 0);
        f1 = b[7 - 2 * p];
        f0 = b[6 - 2 * p];
        fdrv = 1'b1;
    end

    // monitor: scoreboard and timing
    logic prev_sclk = 1'b0, prev_cs = 1'b1;
    int   hi_run = 0, cs_hi = 0;
    always @(negedge clk) if (rst_n) begin
        if (out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected byte", out_data, 0);
            end else begin
                exp_b = sb_q.pop_front();
                chk(out_data == exp_b, "R6", "byte value", out_data, exp_b);
            end
        end
        if (done) begin
            done_cnt++;
            chk(cs_n && !prev_cs, "R9", "done not at cs rise", {prev_cs, cs_n}, 2'b01);
        end
        if (prev_sclk && !sclk)
            chk(hi_run == HALF, "R7", "sclk high length", hi_run, HALF);
        if (prev_cs && !cs_n)
            chk(cs_hi >= DESEL, "R9", "deselect time", cs_hi, DESEL);
        hi_run = sclk ? hi_run + 1 : 0;
        cs_hi  = cs_n ? cs_hi + 1 : 0;
        prev_sclk = sclk;
        prev_cs   = cs_n;
    end

    task automatic run_xfer(input logic [23:0] addr, input int len,
                            input int rmode, input bit intrude);
        int d0, c0;
        rdy_mode = rmode;
        exp_addr = addr & MASK;
        exp_len  = len;
        for (int j = 0; j < len; j++)
            sb_q.push_back(byte_at(exp_addr + 24'(j)));
        d0 = done_cnt;
        c0 = cs_fall_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R10", "busy after accept", busy, 1);
        if (intrude) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_addr = 24'h123456; req_len = 7;
            repeat (10) @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy || sb_q.size() != 0) @(negedge clk);
        chk(done_cnt == d0 + 1, "R9", "done pulses", done_cnt - d0, 1);
        chk(cs_fall_cnt == c0 + 1, "R10", "select periods", cs_fall_cnt - c0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n && !sclk && !busy && !out_valid && !io0_en && !io1_en,
            "R1", "reset state", {cs_n, sclk, busy, out_valid, io0_en, io1_en}, 6'b100000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        run_xfer(24'hAB12F0, 5, 0, 1'b0);
        run_xfer(24'h7FFFFE, 4, 1, 1'b1);
        run_xfer(24'hFF0420, 12, 2, 1'b0);
        run_xfer(24'h00A5C3, 1, 1, 1'b0);

        // R11: zero length
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h000100; req_len = '0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) begin
            @(negedge clk);
            chk(!busy && cs_n, "R11", "zero-length started", {busy, cs_n}, 2'b01);
        end

        run_xfer(24'h01FFFF, 6, 0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule